// File: doc/BRIEF.md
# Debug Port Unlock Sequence Detector

This block sits on the debug clock and the debug data line and watches for protocol-switch sequences. It looks for them while the chip's system reset is held asserted. A switch is a run of at least 50 clocks with the data line high, followed by a 16-bit switch code sampled on rising edges, least significant bit first. Code 0xE79E is a JTAG-to-SWD switch and code 0xE73C is an SWD-to-JTAG switch.

Switches are counted only while system reset stays asserted. They must alternate, and the first one must go from JTAG to SWD. When the tenth correctly ordered switch is recognized, the block issues a single-cycle mass-erase request. It then waits for the flash side to report that the erase has finished, and issues a single-cycle request to restore the non-volatile registers to their defaults.

A mode flag follows every recognized switch, whether or not it counts. Power-on reset clears all state and sets the flag to JTAG.

Top module: `dp_unlock_det`

## Requirements
- R1: After power-on reset (`rst_ni` low), `erase_req_o` and `restore_req_o` are 0 and `swd_mode_o` is 0 (JTAG).
- R2: A JTAG-to-SWD switch is recognized when at least 50 rising edges sample `swdio_i` high, followed by the 16 bits of 0xE79E sampled least significant bit first. Recognition sets `swd_mode_o` to 1.
- R3: An SWD-to-JTAG switch is recognized by the same 50-high preamble followed by 0xE73C, least significant bit first. Recognition sets `swd_mode_o` to 0.
- R4: If fewer than 50 consecutive high samples come before the code, no switch is recognized and `swd_mode_o` is unchanged.
- R5: While `sys_rst_i` stays 1, ten switches that alternate and start with JTAG-to-SWD cause exactly one `erase_req_o` pulse, one cycle wide. It is high in the cycle after the second rising edge that follows the edge sampling the final code bit.
- R6: Nine correctly alternated switches produce no erase request.
- R7: A switch that arrives out of order clears the count to zero and is not itself counted. This includes an SWD-to-JTAG switch at count zero.
- R8: Driving `sys_rst_i` to 0 clears the count to zero.
- R9: After an erase request, `restore_req_o` pulses for one cycle, on the edge after `erase_done_i` is sampled high. When no erase is pending, `erase_done_i` has no effect.
- R10: Switches recognized while `sys_rst_i` is 0 change `swd_mode_o` but are never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debug clock; rising edge samples the data line |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | System reset held asserted (1) |
| swdio_i | input | 1 | Debug data / mode-select line |
| erase_done_i | input | 1 | Flash side reports mass erase finished |
| erase_req_o | output | 1 | One-cycle mass-erase request |
| restore_req_o | output | 1 | One-cycle non-volatile restore request |
| swd_mode_o | output | 1 | Current protocol: 1 = SWD, 0 = JTAG |

## Verification
A corrupted shift register or preamble counter shows up as a wrong `swd_mode_o` two edges after a code's final bit. A lost or duplicated switch count shows up only later, as an erase pulse that is missing, early or repeated when the tenth switch completes. For that reason the bench tracks the number of erase pulses after every switch in the runs of nine and ten, not only at the end. A stuck erase sequencer shows up as a restore pulse with no erase before it, or as no restore pulse one edge after the done input.

// File: rtl/dp_unlock_pkg.sv
package dp_unlock_pkg;
  localparam int unsigned PRE_HIGH_MIN = 50;
  localparam int unsigned SW_CODE_W    = 16;
  localparam int unsigned UNLOCK_CNT   = 10;
  localparam logic [SW_CODE_W-1:0] CODE_J2S = 16'hE79E;
  localparam logic [SW_CODE_W-1:0] CODE_S2J = 16'hE73C;

  typedef enum logic {ER_IDLE, ER_WAIT} er_state_e;
endpackage

// File: rtl/dp_switch_detect.sv
module dp_switch_detect #(
  parameter int unsigned HIGH_MIN = 50,
  parameter int unsigned CODE_W   = 16,
  parameter logic [CODE_W-1:0] J2S_CODE = '0,
  parameter logic [CODE_W-1:0] S2J_CODE = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic j2s_o,
  output logic s2j_o
);
  localparam int unsigned HW = $clog2(HIGH_MIN + 1);
  localparam int unsigned BW = $clog2(CODE_W);

  logic [HW-1:0]     high_q;
  logic [BW-1:0]     bit_q;
  logic [CODE_W-1:0] sh_q, sh_nxt;
  logic              collect_q, j2s_q, s2j_q;
  logic              armed, last_bit;

  assign armed    = (high_q == HW'(HIGH_MIN));
  assign sh_nxt   = {din_i, sh_q[CODE_W-1:1]};   // LSB arrives first
  assign last_bit = collect_q && (bit_q == BW'(CODE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_q    <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      collect_q <= 1'b0;
      j2s_q     <= 1'b0;
      s2j_q     <= 1'b0;
    end else begin
      if (din_i) high_q <= armed ? high_q : high_q + 1'b1;
      else       high_q <= '0;
      j2s_q <= 1'b0;
      s2j_q <= 1'b0;
      if (collect_q) begin
        sh_q  <= sh_nxt;
        bit_q <= bit_q + 1'b1;
        if (last_bit) begin
          collect_q <= 1'b0;
          j2s_q     <= (sh_nxt == J2S_CODE);
          s2j_q     <= (sh_nxt == S2J_CODE);
        end
      end else if (!din_i && armed) begin
        // first code bit (low) after a long enough high run
        collect_q <= 1'b1;
        sh_q      <= sh_nxt;
        bit_q     <= BW'(1);
      end
    end
  end

  assign j2s_o = j2s_q;
  assign s2j_o = s2j_q;

  a_r2_j2s_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    j2s_q |=> !j2s_q);
  a_r3_s2j_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2j_q |=> !s2j_q);
  a_r4_needs_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!collect_q && !din_i && !armed) |=> !collect_q);
endmodule

// File: rtl/dp_unlock_seq.sv
module dp_unlock_seq #(
  parameter int unsigned UNLOCK_COUNT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic j2s_i,
  input  logic s2j_i,
  output logic mode_o,
  output logic unlock_o
);
  localparam int unsigned CW = $clog2(UNLOCK_COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(UNLOCK_COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic          mode_q, unlock_q;
  logic          want_j2s, good, bad;

  assign want_j2s = ~cnt_q[0];   // even counts expect JTAG-to-SWD
  assign good     = want_j2s ? j2s_i : s2j_i;
  assign bad      = want_j2s ? s2j_i : j2s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= 1'b0;
      if (j2s_i)      mode_q <= 1'b1;
      else if (s2j_i) mode_q <= 1'b0;
      if (!sys_rst_i || bad) begin
        cnt_q <= '0;
      end else if (good) begin
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          unlock_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mode_o   = mode_q;
  assign unlock_o = unlock_q;

  a_r2_mode_swd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    j2s_i |=> mode_q);
  a_r3_mode_jtag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2j_i |=> !mode_q);
  a_r8_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_i |=> (cnt_q == '0) && !unlock_q);
  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(UNLOCK_COUNT));
  a_r7_wrong_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad && !good) |=> (cnt_q == '0) && !unlock_q);
endmodule

// File: rtl/dp_erase_ctrl.sv
module dp_erase_ctrl
  import dp_unlock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_i,
  input  logic erase_done_i,
  output logic erase_req_o,
  output logic restore_req_o
);
  er_state_e state_q;
  logic      erase_q, restore_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ER_IDLE;
      erase_q   <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      erase_q   <= 1'b0;
      restore_q <= 1'b0;
      case (state_q)
        ER_IDLE: if (unlock_i) begin
          erase_q <= 1'b1;
          state_q <= ER_WAIT;
        end
        ER_WAIT: if (erase_done_i) begin
          restore_q <= 1'b1;
          state_q   <= ER_IDLE;
        end
        default: state_q <= ER_IDLE;
      endcase
    end
  end

  assign erase_req_o   = erase_q;
  assign restore_req_o = restore_q;

  a_r5_erase_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_q |=> !erase_q);
  a_r9_restore_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_q |=> !restore_q);
  a_r9_not_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_q && restore_q));
  a_r9_restore_needs_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_q) |-> $past(state_q) == ER_WAIT);
endmodule

// File: rtl/dp_unlock_det.sv
module dp_unlock_det
  import dp_unlock_pkg::*;
#(
  parameter int unsigned HIGH_MIN     = PRE_HIGH_MIN,
  parameter int unsigned UNLOCK_COUNT = UNLOCK_CNT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic swdio_i,
  input  logic erase_done_i,
  output logic erase_req_o,
  output logic restore_req_o,
  output logic swd_mode_o
);
  logic j2s_hit, s2j_hit, unlock;

  dp_switch_detect #(
    .HIGH_MIN (HIGH_MIN),
    .CODE_W   (SW_CODE_W),
    .J2S_CODE (CODE_J2S),
    .S2J_CODE (CODE_S2J)
  ) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (swdio_i),
    .j2s_o  (j2s_hit),
    .s2j_o  (s2j_hit)
  );

  dp_unlock_seq #(.UNLOCK_COUNT(UNLOCK_COUNT)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .j2s_i     (j2s_hit),
    .s2j_i     (s2j_hit),
    .mode_o    (swd_mode_o),
    .unlock_o  (unlock)
  );

  dp_erase_ctrl u_erase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .unlock_i      (unlock),
    .erase_done_i  (erase_done_i),
    .erase_req_o   (erase_req_o),
    .restore_req_o (restore_req_o)
  );

  a_r1_outputs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> !restore_req_o);
endmodule

// File: tb/dp_unlock_det_bench.sv
module dp_unlock_det_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sys_rst = 1'b0;
  logic swdio = 1'b1;
  logic erase_done = 1'b0;
  logic erase_req, restore_req, swd_mode;

  int checks = 0;
  int errors = 0;
  int erase_cnt = 0;
  int restore_cnt = 0;
  bit done = 1'b0;

  localparam logic [15:0] J2S = 16'hE79E;
  localparam logic [15:0] S2J = 16'hE73C;

  always #5 clk = ~clk;

  dp_unlock_det u_dp_unlock_det (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .sys_rst_i     (sys_rst),
    .swdio_i       (swdio),
    .erase_done_i  (erase_done),
    .erase_req_o   (erase_req),
    .restore_req_o (restore_req),
    .swd_mode_o    (swd_mode)
  );

  always @(negedge clk) begin
    if (rst_ni && erase_req)   erase_cnt++;
    if (rst_ni && restore_req) restore_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk) swdio = b;
    @(posedge clk);
  endtask

  task automatic send_switch(input logic [15:0] code, input int pre);
    for (int i = 0; i < pre; i++) drive_bit(1'b1);
    for (int i = 0; i < 16; i++) drive_bit(code[i]);
    for (int i = 0; i < 3; i++) drive_bit(1'b1);   // let the pipeline settle
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 erase", erase_req, 0);
    chk("R1 restore", restore_req, 0);
    chk("R1 mode", swd_mode, 0);
  endtask

  task automatic t_modes;
    sys_rst = 1'b0;
    @(negedge clk) erase_done = 1'b1;
    @(negedge clk) erase_done = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 done ignored when idle", restore_cnt, 0);
    send_switch(J2S, 50);
    chk("R2 mode after j2s", swd_mode, 1);
    send_switch(S2J, 50);
    chk("R3 mode after s2j", swd_mode, 0);
    for (int k = 0; k < 10; k++) send_switch(k[0] ? S2J : J2S, 50);
    chk("R10 no erase outside reset", erase_cnt, 0);
  endtask

  task automatic t_short;
    for (int i = 0; i < 20; i++) drive_bit(1'b0);
    send_switch(J2S, 49);
    chk("R4 short preamble ignored", swd_mode, 0);
  endtask

  task automatic t_nine;
    @(negedge clk) sys_rst = 1'b1;
    for (int k = 0; k < 9; k++) begin
      send_switch(k[0] ? S2J : J2S, 50);
      chk("R6 no erase before tenth", erase_cnt, 0);
    end
    chk("R2 mode after ninth", swd_mode, 1);
    @(negedge clk) sys_rst = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst = 1'b1;
    send_switch(S2J, 50);
    chk("R8 count cleared by release", erase_cnt, 0);
  endtask

  task automatic t_full;
    for (int k = 0; k < 9; k++) send_switch(k[0] ? S2J : J2S, 50);
    for (int i = 0; i < 50; i++) drive_bit(1'b1);
    for (int i = 0; i < 16; i++) drive_bit(S2J[i]);
    @(negedge clk); chk("R5 erase E+0", erase_req, 0);
    @(negedge clk); chk("R5 erase E+1", erase_req, 0);
    @(negedge clk); chk("R5 erase E+2", erase_req, 1);
    @(negedge clk); chk("R5 erase E+3", erase_req, 0);
    repeat (5) @(negedge clk);
    chk("R5 single erase", erase_cnt, 1);
    chk("R9 no restore before done", restore_cnt, 0);
    erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk("R9 restore after done", restore_req, 1);
    @(negedge clk); chk("R9 restore one cycle", restore_req, 0);
    chk("R9 restore count", restore_cnt, 1);
  endtask

  task automatic t_order;
    send_switch(J2S, 50);
    send_switch(S2J, 50);
    send_switch(J2S, 50);
    send_switch(J2S, 50);   // out of order: clears
    for (int k = 0; k < 9; k++) send_switch(k[0] ? S2J : J2S, 50);
    chk("R7 wrong order cleared count", erase_cnt, 1);
    send_switch(S2J, 50);
    chk("R7 erase after fresh ten", erase_cnt, 2);
    chk("R3 mode after last", swd_mode, 0);
    @(negedge clk) erase_done = 1'b1;
    @(negedge clk) erase_done = 1'b0;
    @(negedge clk);
    chk("R9 second restore", restore_cnt, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_modes;
    t_short;
    t_nine;
    t_full;
    t_order;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule